// File: doc/BRIEF.md
# Window-Protected Tile Writer

This block sits in front of a frame buffer and decides which pixels of an incoming 8x8 tile may be written. A client names a window and an offset inside it. The block keeps a small table of windows, each with a screen origin and a width and height. It also keeps an owner map that holds one window tag for every screen pixel. For each accepted tile it produces one output beat per pixel, one beat per clock. Each beat carries the screen address, the pixel value and a write enable. The write enable is high only when three things hold: the pixel lies inside the window's box, the pixel is on the screen, and the owner map shows that the requesting window owns that pixel.

A control port, separate from the tile path, creates, destroys, moves and resizes windows. A geometry change repaints the owner map one pixel per clock. The repaint first releases the pixels the window held in its old rectangle. It then claims every pixel of its new rectangle, so the most recently placed window sits on top. While a repaint runs, tiles are held off. A request for a window that is not allocated is dropped whole and flagged.

Top module: `tg_tile_guard`

## Requirements
- R1: After reset, `out_valid` and `err_drop` are 0, and both `ctl_ready` and `in_ready` are 1.
- R2: An accepted tile for an allocated window produces exactly 64 output beats in row-major order. Beat p covers tile column p%8 and row p/8, and carries `in_pix[p*8 +: 8]`. Its address is sy*32+sx, where sx = origin_x + off_x + column and sy = origin_y + off_y + row.
- R3: A pixel whose window-relative position (offset plus column or row) is not less than the window width or height has `out_we` = 0.
- R4: `out_we` is 1 only when the owner map holds the requesting window's tag at that screen pixel. A window created later over an earlier one takes the overlapped pixels.
- R5: A tile naming an unallocated window produces no beats. `err_drop` is 1 for exactly the one cycle after the accepting edge.
- R6: Create (`ctl_op` 0) allocates window `ctl_id` at origin (`ctl_x`,`ctl_y`) with width `ctl_w`+1 and height `ctl_h`+1, and claims every on-screen pixel of that rectangle.
- R7: Destroy (`ctl_op` 1) frees the window, so later tiles for it are dropped. Pixels it owned become owned by no window.
- R8: Move (`ctl_op` 2) on an allocated window releases its old pixels and claims the rectangle at the new origin, keeping its size.
- R9: Resize (`ctl_op` 3) on an allocated window releases its old pixels and claims the rectangle of the new size, keeping its origin.
- R10: Pixels whose screen coordinate falls at or beyond the 32x32 screen have `out_we` = 0.
- R11: While `out_valid` is 1 and `out_ready` is 0, the beat's address, data and write enable stay unchanged on the next cycle.
- R12: During a repaint, `ctl_ready` and `in_ready` are 0. While `ctl_valid` is 1, `in_ready` is 0, so control has priority. A repaint never overlaps tile output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_valid | input | 1 | Control command present |
| ctl_ready | output | 1 | Control command accepted at this edge |
| ctl_op | input | 2 | 0 create, 1 destroy, 2 move, 3 resize |
| ctl_id | input | 2 | Window slot |
| ctl_x | input | 5 | New origin column |
| ctl_y | input | 5 | New origin row |
| ctl_w | input | 5 | New width minus one |
| ctl_h | input | 5 | New height minus one |
| in_valid | input | 1 | Tile request present |
| in_ready | output | 1 | Tile request accepted at this edge |
| in_id | input | 2 | Requesting window slot |
| in_off_x | input | 5 | Tile column offset inside the window |
| in_off_y | input | 5 | Tile row offset inside the window |
| in_pix | input | 512 | 64 pixels, pixel p at bits p*8 |
| out_valid | output | 1 | Pixel beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_addr | output | 10 | Screen pixel address |
| out_pix | output | 8 | Pixel value |
| out_we | output | 1 | Pixel may be written |
| err_drop | output | 1 | Pulse: request for an unallocated window dropped |

## Verification
On every cycle the assertions check four things: beats hold still under backpressure, a tile ends only after its 64th beat, a drop pulse follows an accepted request and comes with no beat, and a repaint never runs while a tile is streaming. The actual protection decisions can only be shown by the bench's scenarios, because each depends on the history of window commands. These decisions are clipping at the box and at the screen edge, ownership after an overlap, the unowned state left by destroy, and re-ownership after move and resize. The bench checks them beat by beat against its own window and owner model.

// File: rtl/tg_pkg.sv
// Shared types for the window-protected tile writer.
package tg_pkg;

    // Control command codes; the encoding is visible on the ctl_op port.
    typedef enum logic [1:0] {
        WOP_CREATE  = 2'd0,
        WOP_DESTROY = 2'd1,
        WOP_MOVE    = 2'd2,
        WOP_RESIZE  = 2'd3
    } win_op_e;

    // Phases of the owner-map repaint walker.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_RELEASE = 2'd1,
        PH_CLAIM   = 2'd2
    } paint_ph_e;

endpackage

// File: rtl/tg_win_table.sv
// Window table: one slot per window holding allocation, origin and size-1.
// Decodes a control command into a repaint job (old and new rectangles).
// Assumes cmd_fire is only raised when the repaint walker is idle.
module tg_win_table #(
    parameter int NUM_WIN = 4,
    parameter int XW      = 5,
    parameter int YW      = 5,
    parameter int IDW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fire,
    input  tg_pkg::win_op_e   cmd_op,
    input  logic [IDW-1:0]    cmd_id,
    input  logic [XW-1:0]     cmd_x,
    input  logic [YW-1:0]     cmd_y,
    input  logic [XW-1:0]     cmd_wm,
    input  logic [YW-1:0]     cmd_hm,
    output logic              job_rel,
    output logic              job_claim,
    output logic [XW-1:0]     old_x,
    output logic [YW-1:0]     old_y,
    output logic [XW-1:0]     old_wm,
    output logic [YW-1:0]     old_hm,
    output logic [XW-1:0]     new_x,
    output logic [YW-1:0]     new_y,
    output logic [XW-1:0]     new_wm,
    output logic [YW-1:0]     new_hm,
    input  logic [IDW-1:0]    lk_id,
    output logic              lk_alloc,
    output logic [XW-1:0]     lk_x,
    output logic [YW-1:0]     lk_y,
    output logic [XW-1:0]     lk_wm,
    output logic [YW-1:0]     lk_hm
);
    import tg_pkg::*;

    logic          alloc_v [NUM_WIN];
    logic [XW-1:0] x_v     [NUM_WIN];
    logic [YW-1:0] y_v     [NUM_WIN];
    logic [XW-1:0] wm_v    [NUM_WIN];
    logic [YW-1:0] hm_v    [NUM_WIN];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_slot
        logic          s_alloc;
        logic [XW-1:0] s_x, s_wm;
        logic [YW-1:0] s_y, s_hm;
        logic          hit;

        assign hit = cmd_fire && (cmd_id == IDW'(g));

        // Apply a command addressed to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_alloc <= 1'b0;
                s_x     <= '0;
                s_y     <= '0;
                s_wm    <= '0;
                s_hm    <= '0;
            end else if (hit) begin
                case (cmd_op)
                    WOP_CREATE: begin
                        s_alloc <= 1'b1;
                        s_x     <= cmd_x;
                        s_y     <= cmd_y;
                        s_wm    <= cmd_wm;
                        s_hm    <= cmd_hm;
                    end
                    WOP_DESTROY: s_alloc <= 1'b0;
                    WOP_MOVE: if (s_alloc) begin
                        s_x <= cmd_x;
                        s_y <= cmd_y;
                    end
                    default: if (s_alloc) begin
                        s_wm <= cmd_wm;
                        s_hm <= cmd_hm;
                    end
                endcase
            end
        end

        assign alloc_v[g] = s_alloc;
        assign x_v[g]     = s_x;
        assign y_v[g]     = s_y;
        assign wm_v[g]    = s_wm;
        assign hm_v[g]    = s_hm;
    end

    // Turn the command into release/claim rectangles from the current slot.
    always_comb begin
        old_x     = x_v[cmd_id];
        old_y     = y_v[cmd_id];
        old_wm    = wm_v[cmd_id];
        old_hm    = hm_v[cmd_id];
        job_rel   = alloc_v[cmd_id];
        job_claim = 1'b0;
        new_x     = old_x;
        new_y     = old_y;
        new_wm    = old_wm;
        new_hm    = old_hm;
        case (cmd_op)
            WOP_CREATE: begin
                job_claim = 1'b1;
                new_x     = cmd_x;
                new_y     = cmd_y;
                new_wm    = cmd_wm;
                new_hm    = cmd_hm;
            end
            WOP_DESTROY: job_claim = 1'b0;
            WOP_MOVE: begin
                job_claim = alloc_v[cmd_id];
                new_x     = cmd_x;
                new_y     = cmd_y;
            end
            default: begin
                job_claim = alloc_v[cmd_id];
                new_wm    = cmd_wm;
                new_hm    = cmd_hm;
            end
        endcase
    end

    // Lookup port used by the tile path.
    assign lk_alloc = alloc_v[lk_id];
    assign lk_x     = x_v[lk_id];
    assign lk_y     = y_v[lk_id];
    assign lk_wm    = wm_v[lk_id];
    assign lk_hm    = hm_v[lk_id];

endmodule

// File: rtl/tg_owner_map.sv
// Per-pixel owner map (tag 0 = nobody, tag k+1 = window slot k) plus the
// repaint walker. The walker runs one pixel per clock: it first releases
// the pixels the window still owns in its old rectangle, then claims the
// whole new rectangle. Pixels off the screen are skipped.
// Assumes start is only raised while idle, and that the tile path is idle
// whenever the walker runs.
module tg_owner_map #(
    parameter int SCR_W = 32,
    parameter int SCR_H = 32,
    parameter int XW    = 5,
    parameter int YW    = 5,
    parameter int AW    = 10,
    parameter int TAGW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            job_rel,
    input  logic            job_claim,
    input  logic [TAGW-1:0] tag,
    input  logic [XW-1:0]   old_x,
    input  logic [YW-1:0]   old_y,
    input  logic [XW-1:0]   old_wm,
    input  logic [YW-1:0]   old_hm,
    input  logic [XW-1:0]   new_x,
    input  logic [YW-1:0]   new_y,
    input  logic [XW-1:0]   new_wm,
    input  logic [YW-1:0]   new_hm,
    output logic            busy,
    input  logic            tile_busy,
    input  logic [AW-1:0]   rd_addr,
    output logic [TAGW-1:0] rd_tag
);
    import tg_pkg::*;

    localparam int NPIX = SCR_W * SCR_H;

    logic [TAGW-1:0] own_q [NPIX];

    paint_ph_e       ph_q;
    logic [XW-1:0]   bx_q, wm_q, cx_q, px_q, pwm_q;
    logic [YW-1:0]   by_q, hm_q, cy_q, py_q, phm_q;
    logic            pclaim_q;
    logic [TAGW-1:0] tag_q;

    logic [XW:0]     sx;
    logic [YW:0]     sy;
    logic            on_scr;
    logic [AW-1:0]   wr_addr;
    logic            wr_en;
    logic [TAGW-1:0] wr_val;
    logic            last_col, last_row;

    // Current walker pixel in screen space and the write it implies.
    always_comb begin
        sx       = (XW+1)'(bx_q) + (XW+1)'(cx_q);
        sy       = (YW+1)'(by_q) + (YW+1)'(cy_q);
        on_scr   = (sx < (XW+1)'(SCR_W)) && (sy < (YW+1)'(SCR_H));
        wr_addr  = AW'(sy) * AW'(SCR_W) + AW'(sx);
        wr_val   = (ph_q == PH_CLAIM) ? tag_q : '0;
        wr_en    = (ph_q != PH_IDLE) && on_scr &&
                   ((ph_q == PH_CLAIM) || (own_q[wr_addr] == tag_q));
        last_col = (cx_q == wm_q);
        last_row = (cy_q == hm_q);
    end

    // Owner storage: cleared at reset, one entry written per walker step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPIX; i++) own_q[i] <= '0;
        end else if (wr_en) begin
            own_q[wr_addr] <= wr_val;
        end
    end

    // Walker sequencing across the release and claim phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= PH_IDLE;
            bx_q     <= '0;
            by_q     <= '0;
            wm_q     <= '0;
            hm_q     <= '0;
            cx_q     <= '0;
            cy_q     <= '0;
            px_q     <= '0;
            py_q     <= '0;
            pwm_q    <= '0;
            phm_q    <= '0;
            pclaim_q <= 1'b0;
            tag_q    <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (start) begin
                    tag_q    <= tag;
                    px_q     <= new_x;
                    py_q     <= new_y;
                    pwm_q    <= new_wm;
                    phm_q    <= new_hm;
                    pclaim_q <= job_claim;
                    cx_q     <= '0;
                    cy_q     <= '0;
                    if (job_rel) begin
                        ph_q <= PH_RELEASE;
                        bx_q <= old_x;
                        by_q <= old_y;
                        wm_q <= old_wm;
                        hm_q <= old_hm;
                    end else if (job_claim) begin
                        ph_q <= PH_CLAIM;
                        bx_q <= new_x;
                        by_q <= new_y;
                        wm_q <= new_wm;
                        hm_q <= new_hm;
                    end
                end
                default: begin
                    if (last_col) begin
                        cx_q <= '0;
                        if (last_row) begin
                            cy_q <= '0;
                            if (ph_q == PH_RELEASE && pclaim_q) begin
                                ph_q <= PH_CLAIM;
                                bx_q <= px_q;
                                by_q <= py_q;
                                wm_q <= pwm_q;
                                hm_q <= phm_q;
                            end else begin
                                ph_q <= PH_IDLE;
                            end
                        end else begin
                            cy_q <= cy_q + YW'(1);
                        end
                    end else begin
                        cx_q <= cx_q + XW'(1);
                    end
                end
            endcase
        end
    end

    assign busy   = (ph_q != PH_IDLE);
    assign rd_tag = own_q[rd_addr];

    AST_PAINT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tile_busy); // R12

endmodule

// File: rtl/tg_tile_walker.sv
// Tile walker: latches an accepted tile and streams one pixel beat per
// clock in row-major order. Each beat computes the window-relative and the
// screen position, reads the owner map and enables the write only inside
// the box, on screen, and on pixels owned by the requester.
// Raises a one-cycle error for a dropped request.
// Assumes TILE is a power of two and the owner map is frozen while busy.
module tg_tile_walker #(
    parameter int SCR_W = 32,
    parameter int SCR_H = 32,
    parameter int TILE  = 8,
    parameter int PIX_W = 8,
    parameter int XW    = 5,
    parameter int YW    = 5,
    parameter int AW    = 10,
    parameter int TAGW  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        drop,
    input  logic [XW-1:0]               org_x,
    input  logic [YW-1:0]               org_y,
    input  logic [XW-1:0]               wm,
    input  logic [YW-1:0]               hm,
    input  logic [XW-1:0]               off_x,
    input  logic [YW-1:0]               off_y,
    input  logic [TAGW-1:0]             tag,
    input  logic [TILE*TILE*PIX_W-1:0]  pix,
    output logic [AW-1:0]               rd_addr,
    input  logic [TAGW-1:0]             rd_tag,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [AW-1:0]               out_addr,
    output logic [PIX_W-1:0]            out_pix,
    output logic                        out_we,
    output logic                        busy,
    output logic                        err
);
    localparam int TPIX = TILE * TILE;
    localparam int TIW  = $clog2(TPIX);
    localparam int TCW  = $clog2(TILE);

    logic                   busy_q, err_q;
    logic [TIW-1:0]         idx_q;
    logic [TPIX*PIX_W-1:0]  pix_q;
    logic [XW-1:0]          ox_q, wm_q, fx_q;
    logic [YW-1:0]          oy_q, hm_q, fy_q;
    logic [TAGW-1:0]        tag_q;

    logic [TCW-1:0]         col, row;
    logic [XW:0]            relx;
    logic [YW:0]            rely;
    logic [XW+1:0]          sx;
    logic [YW+1:0]          sy;
    logic                   inbox, on_scr;

    // Position of the current beat in window and screen space.
    always_comb begin
        col      = idx_q[TCW-1:0];
        row      = idx_q[TIW-1:TCW];
        relx     = (XW+1)'(fx_q) + (XW+1)'(col);
        rely     = (YW+1)'(fy_q) + (YW+1)'(row);
        inbox    = (relx <= (XW+1)'(wm_q)) && (rely <= (YW+1)'(hm_q));
        sx       = (XW+2)'(ox_q) + (XW+2)'(relx);
        sy       = (YW+2)'(oy_q) + (YW+2)'(rely);
        on_scr   = (sx < (XW+2)'(SCR_W)) && (sy < (YW+2)'(SCR_H));
        rd_addr  = AW'(sy) * AW'(SCR_W) + AW'(sx);
    end

    assign out_valid = busy_q;
    assign out_addr  = rd_addr;
    assign out_pix   = pix_q[idx_q*PIX_W +: PIX_W];
    assign out_we    = busy_q && inbox && on_scr && (rd_tag == tag_q);
    assign busy      = busy_q;
    assign err       = err_q;

    // Tile capture, beat advance and drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            idx_q  <= '0;
            pix_q  <= '0;
            ox_q   <= '0;
            oy_q   <= '0;
            wm_q   <= '0;
            hm_q   <= '0;
            fx_q   <= '0;
            fy_q   <= '0;
            tag_q  <= '0;
        end else begin
            err_q <= drop;
            if (start) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                pix_q  <= pix;
                ox_q   <= org_x;
                oy_q   <= org_y;
                wm_q   <= wm;
                hm_q   <= hm;
                fx_q   <= off_x;
                fy_q   <= off_y;
                tag_q  <= tag;
            end else if (busy_q && out_ready) begin
                if (idx_q == TIW'(TPIX-1)) busy_q <= 1'b0;
                idx_q <= idx_q + TIW'(1);
            end
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
        $stable(out_pix) && $stable(out_we))); // R11

    AST_TILE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(idx_q) == TIW'(TPIX-1))); // R2

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !out_valid); // R5

endmodule

// File: rtl/tg_tile_guard.sv
// Top: window-protected tile writer. Joins the window table, the owner map
// with its repaint walker and the tile walker. Control has priority over
// tiles, and neither is accepted while a repaint or a tile is in progress.
// Assumes a power-of-two tile edge; window slot k uses owner tag k+1.
module tg_tile_guard #(
    parameter int SCR_W   = 32,
    parameter int SCR_H   = 32,
    parameter int NUM_WIN = 4,
    parameter int TILE    = 8,
    parameter int PIX_W   = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                ctl_valid,
    output logic                                ctl_ready,
    input  logic [1:0]                          ctl_op,
    input  logic [$clog2(NUM_WIN)-1:0]          ctl_id,
    input  logic [$clog2(SCR_W)-1:0]            ctl_x,
    input  logic [$clog2(SCR_H)-1:0]            ctl_y,
    input  logic [$clog2(SCR_W)-1:0]            ctl_w,
    input  logic [$clog2(SCR_H)-1:0]            ctl_h,
    input  logic                                in_valid,
    output logic                                in_ready,
    input  logic [$clog2(NUM_WIN)-1:0]          in_id,
    input  logic [$clog2(SCR_W)-1:0]            in_off_x,
    input  logic [$clog2(SCR_H)-1:0]            in_off_y,
    input  logic [TILE*TILE*PIX_W-1:0]          in_pix,
    output logic                                out_valid,
    input  logic                                out_ready,
    output logic [$clog2(SCR_W*SCR_H)-1:0]      out_addr,
    output logic [PIX_W-1:0]                    out_pix,
    output logic                                out_we,
    output logic                                err_drop
);
    import tg_pkg::*;

    localparam int XW   = $clog2(SCR_W);
    localparam int YW   = $clog2(SCR_H);
    localparam int AW   = $clog2(SCR_W * SCR_H);
    localparam int IDW  = $clog2(NUM_WIN);
    localparam int TAGW = $clog2(NUM_WIN + 1);

    logic            ctl_fire, tile_fire, tile_start, tile_drop;
    logic            paint_busy, tile_busy;
    logic            job_rel, job_claim;
    logic [XW-1:0]   old_x, old_wm, new_x, new_wm, lk_x, lk_wm;
    logic [YW-1:0]   old_y, old_hm, new_y, new_hm, lk_y, lk_hm;
    logic            lk_alloc;
    logic [AW-1:0]   rd_addr;
    logic [TAGW-1:0] rd_tag;
    logic [TAGW-1:0] ctl_tag, in_tag;

    // Acceptance: control first, both blocked while anything is running.
    assign ctl_ready  = !paint_busy && !tile_busy;
    assign in_ready   = !paint_busy && !tile_busy && !ctl_valid;
    assign ctl_fire   = ctl_valid && ctl_ready;
    assign tile_fire  = in_valid && in_ready;
    assign tile_start = tile_fire && lk_alloc;
    assign tile_drop  = tile_fire && !lk_alloc;
    assign ctl_tag    = TAGW'(ctl_id) + TAGW'(1);
    assign in_tag     = TAGW'(in_id) + TAGW'(1);

    tg_win_table #(
        .NUM_WIN (NUM_WIN),
        .XW      (XW),
        .YW      (YW),
        .IDW     (IDW)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_fire  (ctl_fire),
        .cmd_op    (win_op_e'(ctl_op)),
        .cmd_id    (ctl_id),
        .cmd_x     (ctl_x),
        .cmd_y     (ctl_y),
        .cmd_wm    (ctl_w),
        .cmd_hm    (ctl_h),
        .job_rel   (job_rel),
        .job_claim (job_claim),
        .old_x     (old_x),
        .old_y     (old_y),
        .old_wm    (old_wm),
        .old_hm    (old_hm),
        .new_x     (new_x),
        .new_y     (new_y),
        .new_wm    (new_wm),
        .new_hm    (new_hm),
        .lk_id     (in_id),
        .lk_alloc  (lk_alloc),
        .lk_x      (lk_x),
        .lk_y      (lk_y),
        .lk_wm     (lk_wm),
        .lk_hm     (lk_hm)
    );

    tg_owner_map #(
        .SCR_W (SCR_W),
        .SCR_H (SCR_H),
        .XW    (XW),
        .YW    (YW),
        .AW    (AW),
        .TAGW  (TAGW)
    ) u_owner (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ctl_fire),
        .job_rel   (job_rel),
        .job_claim (job_claim),
        .tag       (ctl_tag),
        .old_x     (old_x),
        .old_y     (old_y),
        .old_wm    (old_wm),
        .old_hm    (old_hm),
        .new_x     (new_x),
        .new_y     (new_y),
        .new_wm    (new_wm),
        .new_hm    (new_hm),
        .busy      (paint_busy),
        .tile_busy (tile_busy),
        .rd_addr   (rd_addr),
        .rd_tag    (rd_tag)
    );

    tg_tile_walker #(
        .SCR_W (SCR_W),
        .SCR_H (SCR_H),
        .TILE  (TILE),
        .PIX_W (PIX_W),
        .XW    (XW),
        .YW    (YW),
        .AW    (AW),
        .TAGW  (TAGW)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tile_start),
        .drop      (tile_drop),
        .org_x     (lk_x),
        .org_y     (lk_y),
        .wm        (lk_wm),
        .hm        (lk_hm),
        .off_x     (in_off_x),
        .off_y     (in_off_y),
        .tag       (in_tag),
        .pix       (in_pix),
        .rd_addr   (rd_addr),
        .rd_tag    (rd_tag),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_addr  (out_addr),
        .out_pix   (out_pix),
        .out_we    (out_we),
        .busy      (tile_busy),
        .err       (err_drop)
    );

    AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_drop |-> $past(in_valid && in_ready)); // R5

endmodule

// File: tb/tg_tile_guard_bench.sv
// Directed bench: keeps its own window/owner model and checks every beat.
module tg_tile_guard_bench;
    localparam int CLK_NS = 10;
    localparam int SW = 32, SH = 32, NW = 4, PW = 8, T = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctl_valid = 1'b0;
    logic         ctl_ready;
    logic [1:0]   ctl_op = '0;
    logic [1:0]   ctl_id = '0;
    logic [4:0]   ctl_x = '0, ctl_y = '0, ctl_w = '0, ctl_h = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [1:0]   in_id = '0;
    logic [4:0]   in_off_x = '0, in_off_y = '0;
    logic [511:0] in_pix = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [9:0]   out_addr;
    logic [7:0]   out_pix;
    logic         out_we;
    logic         err_drop;

    int n_chk = 0;
    int n_bad = 0;

    int m_own [SW*SH];
    bit m_alloc [NW];
    int m_x [NW], m_y [NW], m_w [NW], m_h [NW];

    always #(CLK_NS/2) clk = ~clk;

    tg_tile_guard u_tg_tile_guard (
        .clk(clk), .rst_n(rst_n),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_op(ctl_op),
        .ctl_id(ctl_id), .ctl_x(ctl_x), .ctl_y(ctl_y), .ctl_w(ctl_w), .ctl_h(ctl_h),
        .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id),
        .in_off_x(in_off_x), .in_off_y(in_off_y), .in_pix(in_pix),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_pix(out_pix), .out_we(out_we), .err_drop(err_drop)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic paint(input int id, input int x, input int y, input int w,
                         input int h, input bit rel);
        for (int cy = 0; cy < h; cy++)
            for (int cx = 0; cx < w; cx++) begin
                int sx = x + cx;
                int sy = y + cy;
                if (sx < SW && sy < SH) begin
                    if (rel) begin
                        if (m_own[sy*SW+sx] == id + 1) m_own[sy*SW+sx] = 0;
                    end else begin
                        m_own[sy*SW+sx] = id + 1;
                    end
                end
            end
    endtask

    // Issue one control command and update the model; op codes per R6..R9.
    task automatic do_ctl(input int op, input int id, input int x, input int y,
                          input int w, input int h, input string req);
        bit was = m_alloc[id];
        bit repaint = (op == 0) || was;
        if (was && repaint) paint(id, m_x[id], m_y[id], m_w[id], m_h[id], 1'b1);
        case (op)
            0: begin m_alloc[id] = 1'b1; m_x[id] = x; m_y[id] = y; m_w[id] = w; m_h[id] = h; end
            1: m_alloc[id] = 1'b0;
            2: if (was) begin m_x[id] = x; m_y[id] = y; end
            default: if (was) begin m_w[id] = w; m_h[id] = h; end
        endcase
        if (m_alloc[id] && repaint) paint(id, m_x[id], m_y[id], m_w[id], m_h[id], 1'b0);
        @(negedge clk);
        while (!ctl_ready) @(negedge clk);
        ctl_valid = 1'b1; ctl_op = 2'(op); ctl_id = 2'(id);
        ctl_x = 5'(x); ctl_y = 5'(y); ctl_w = 5'(w - 1); ctl_h = 5'(h - 1);
        #1;
        chk(in_ready == 1'b0, "R12 in_ready while ctl_valid", int'(in_ready), 0);
        @(posedge clk);
        #1 ctl_valid = 1'b0;
        @(negedge clk);
        if (repaint)
            chk(ctl_ready == 1'b0 && in_ready == 1'b0, {req, " R12 busy during repaint"},
                int'(ctl_ready) + int'(in_ready), 0);
        while (!ctl_ready) @(negedge clk);
    endtask

    // Send one tile and check every beat against the model; returns enabled count.
    task automatic run_tile(input int id, input int ox, input int oy, input int seed,
                            input string req, output int en);
        int got = 0;
        int cyc = 0;
        bit stalled = 1'b0;
        logic [9:0] h_addr;
        logic [7:0] h_pix;
        logic h_we;
        en = 0;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_id = 2'(id); in_off_x = 5'(ox); in_off_y = 5'(oy);
        for (int p = 0; p < T*T; p++) in_pix[p*8 +: 8] = 8'(seed + p);
        @(posedge clk);
        #1 in_valid = 1'b0;
        if (!m_alloc[id]) begin
            @(negedge clk);
            chk(err_drop == 1'b1, {req, " R5 drop flag"}, int'(err_drop), 1);
            chk(out_valid == 1'b0, {req, " R5 no beats"}, int'(out_valid), 0);
            @(negedge clk);
            chk(err_drop == 1'b0 && out_valid == 1'b0, {req, " R5 one-cycle flag"},
                int'(err_drop) + int'(out_valid), 0);
            return;
        end
        while (got < T*T && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (stalled)
                chk(out_valid && out_addr == h_addr && out_pix == h_pix && out_we == h_we,
                    "R11 beat held", int'(out_addr), int'(h_addr));
            out_ready = (cyc % 4) != 3;
            #1;
            stalled = out_valid && !out_ready;
            h_addr = out_addr; h_pix = out_pix; h_we = out_we;
            if (out_valid && out_ready) begin
                int c = got % T;
                int r = got / T;
                int rx = ox + c;
                int ry = oy + r;
                int sx = m_x[id] + rx;
                int sy = m_y[id] + ry;
                bit inb = rx < m_w[id] && ry < m_h[id];
                bit ons = sx < SW && sy < SH;
                bit own = ons && (m_own[sy*SW+sx] == id + 1);
                bit ewe = inb && ons && own;
                chk(out_we == ewe, {req, " R3/R4/R10 write enable"}, int'(out_we), int'(ewe));
                if (ewe) begin
                    en++;
                    chk(int'(out_addr) == sy*SW + sx, {req, " R2 address"},
                        int'(out_addr), sy*SW + sx);
                    chk(out_pix == 8'(seed + got), {req, " R2 data"},
                        int'(out_pix), int'(8'(seed + got)));
                end
                got++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(got == T*T && out_valid == 1'b0, {req, " R2 beat count"}, got, T*T);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0 && err_drop == 1'b0, "R1 outputs idle",
            int'(out_valid) + int'(err_drop), 0);
        chk(ctl_ready == 1'b1 && in_ready == 1'b1, "R1 ready high",
            int'(ctl_ready) + int'(in_ready), 2);
    endtask

    task automatic t_unallocated();
        int en;
        run_tile(3, 0, 0, 5, "R5 unallocated", en);
    endtask

    task automatic t_create_and_clip();
        int en;
        do_ctl(0, 0, 2, 3, 16, 16, "R6");
        run_tile(0, 0, 0, 16, "R6 full tile", en);
        chk(en == 64, "R6 enabled pixels", en, 64);
        run_tile(0, 12, 12, 40, "R3 clip", en);
        chk(en == 16, "R3 enabled pixels", en, 16);
    endtask

    task automatic t_overlap();
        int en;
        do_ctl(0, 1, 10, 10, 8, 8, "R4");
        run_tile(0, 8, 7, 70, "R4 covered", en);
        chk(en == 0, "R4 covered pixels blocked", en, 0);
        run_tile(1, 0, 0, 90, "R4 owner", en);
        chk(en == 64, "R4 owner writes", en, 64);
    endtask

    task automatic t_destroy();
        int en;
        do_ctl(1, 1, 0, 0, 1, 1, "R7");
        run_tile(1, 0, 0, 3, "R7 destroyed", en);
        run_tile(0, 8, 7, 11, "R7 released", en);
        chk(en == 0, "R7 released pixels unowned", en, 0);
    endtask

    task automatic t_move_resize();
        int en;
        do_ctl(2, 0, 0, 0, 1, 1, "R8");
        run_tile(0, 0, 0, 20, "R8 moved", en);
        chk(en == 64, "R8 enabled after move", en, 64);
        run_tile(0, 8, 7, 30, "R8 reclaimed", en);
        chk(en == 64, "R8 reclaimed pixels", en, 64);
        do_ctl(3, 0, 0, 0, 4, 4, "R9");
        run_tile(0, 0, 0, 50, "R9 resized", en);
        chk(en == 16, "R9 enabled after resize", en, 16);
    endtask

    task automatic t_offscreen();
        int en;
        do_ctl(0, 2, 28, 28, 8, 8, "R10");
        run_tile(2, 0, 0, 60, "R10 edge", en);
        chk(en == 16, "R10 on-screen pixels", en, 16);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < SW*SH; i++) m_own[i] = 0;
        for (int i = 0; i < NW; i++) begin
            m_alloc[i] = 1'b0; m_x[i] = 0; m_y[i] = 0; m_w[i] = 1; m_h[i] = 1;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_unallocated();
        t_create_and_clip();
        t_overlap();
        t_destroy();
        t_move_resize();
        t_offscreen();
        summary();
        $finish;
    end

endmodule